// File: doc/BRIEF.md
# Fused Multiply-Add Special-Operand Resolver

This combinational block sits in front of a single-precision fused multiply-add unit that computes z + x*y, or z - x*y when the negate-product input is set. It sorts each of the three 32-bit operands into one of six classes: signalling NaN, quiet NaN, zero, normal, denormal or infinity. It then decides whether the special cases already fix the result. When they do, it raises a bypass-valid flag and presents the finished 32-bit result, together with an invalid-operation flag. When they do not, the operation must go through the arithmetic datapath, and the block passes that datapath the operand classes and the sign of the product.

The checks follow a fixed priority. A signalling NaN in the addend comes first. Next come the NaNs in the multiplicand pair. Then come infinity times zero, an infinite product, a zero product, and finally a special addend beside a finite nonzero product. All outputs settle in the same cycle as the operands. Normalizing denormals, the arithmetic and rounding belong to other blocks.

Top module: `fma_sc_resolve`

## Requirements
- R1: Each operand is given a 3-bit class code on its class output. The codes are 0 signalling NaN (all exponent bits set, top fraction bit clear, fraction nonzero), 1 quiet NaN (all exponent bits set, top fraction bit set), 2 zero, 3 normal, 4 denormal (exponent zero, fraction nonzero) and 5 infinity (all exponent bits set, fraction zero).
- R2: A signalling-NaN addend overrides every other case. The result is z with fraction bit 22 set, and invalid is raised.
- R3: Otherwise, a signalling-NaN x yields x with bit 22 set, whatever y is. A signalling-NaN y with a non-signalling x yields y with bit 22 set. Invalid is raised in both cases.
- R4: Otherwise, when x or y is a quiet NaN, the result is y unchanged if y is a quiet NaN, else x unchanged. Invalid stays low, and a quiet-NaN addend does not take precedence.
- R5: Infinity times zero, in either order, yields z if z is a quiet NaN, with invalid low. Otherwise the result is the default NaN 32'h7FC00000 and invalid is raised.
- R6: An infinite product (infinity times a nonzero finite value or infinity) yields z if z is a quiet NaN. Otherwise it yields infinity with sign x[31]^y[31]^negate, and any infinite addend is ignored.
- R7: A zero product (zero times zero, normal or denormal) yields z unchanged, even when z is infinite. Invalid stays low and the negate input has no effect on the result.
- R8: A finite nonzero product with an infinite or quiet-NaN addend yields z. With a finite addend, bypass-valid is 0, the bypass result is 0 and invalid is 0.
- R9: The product-sign output always equals x[31]^y[31]^negate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| neg_prod | input | 1 | Negate the product (subtract form) |
| op_z | input | 32 | Addend |
| op_x | input | 32 | Multiplicand |
| op_y | input | 32 | Multiplier |
| byp_vld | output | 1 | Result fixed by special cases |
| byp_res | output | 32 | Bypass result, 0 when not valid |
| inv_op | output | 1 | Invalid-operation flag |
| prod_sgn | output | 1 | Sign of the product for the datapath |
| z_cls | output | 3 | Class code of the addend |
| x_cls | output | 3 | Class code of the multiplicand |
| y_cls | output | 3 | Class code of the multiplier |

## Verification
NaN propagation and the invalid flag can be decided on the same operands. The bench provokes this with a signalling-NaN addend next to a signalling-NaN multiplicand, where the addend's payload must win. It also applies infinity times zero both with and without a quiet-NaN addend, which must return either that addend with invalid low or the default NaN with invalid high. Each case is judged by comparing the full 32-bit result and the flag against values written by hand from the priority rules.

// File: rtl/fma_sc_pkg.sv
package fma_sc_pkg;
  typedef enum logic [2:0] {
    CL_SNAN  = 3'd0,
    CL_QNAN  = 3'd1,
    CL_ZERO  = 3'd2,
    CL_NORM  = 3'd3,
    CL_DNORM = 3'd4,
    CL_INF   = 3'd5
  } fcls_e;
endpackage

// File: rtl/fma_sc_classify.sv
module fma_sc_classify
  import fma_sc_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0] op,
  output fcls_e        cls
);
  logic [EXP_W-1:0]  expo;
  logic [FRAC_W-1:0] frac;

  assign expo = op[W-2 -: EXP_W];
  assign frac = op[FRAC_W-1:0];

  always_comb begin
    if (&expo) begin
      if (frac == '0)            cls = CL_INF;
      else if (frac[FRAC_W-1])   cls = CL_QNAN;
      else                       cls = CL_SNAN;
    end else if (expo == '0) begin
      cls = (frac == '0) ? CL_ZERO : CL_DNORM;
    end else begin
      cls = CL_NORM;
    end
  end
endmodule

// File: rtl/fma_sc_nan_pick.sv
module fma_sc_nan_pick
  import fma_sc_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0] z,
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  fcls_e        zc,
  input  fcls_e        xc,
  input  fcls_e        yc,
  output logic         hit,
  output logic [W-1:0] res,
  output logic         inv
);
  localparam logic [W-1:0] QBIT = {{(W-FRAC_W){1'b0}}, 1'b1, {(FRAC_W-1){1'b0}}};

  always_comb begin
    hit = 1'b1;
    inv = 1'b0;
    res = '0;
    if (zc == CL_SNAN) begin
      inv = 1'b1;
      res = z | QBIT;
    end else if (xc == CL_SNAN) begin
      inv = 1'b1;
      res = x | QBIT;
    end else if (yc == CL_SNAN) begin
      inv = 1'b1;
      res = y | QBIT;
    end else if (yc == CL_QNAN) begin
      res = y;
    end else if (xc == CL_QNAN) begin
      res = x;
    end else begin
      hit = 1'b0;
    end
  end
endmodule

// File: rtl/fma_sc_infzero.sv
module fma_sc_infzero
  import fma_sc_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0] z,
  input  fcls_e        zc,
  input  fcls_e        xc,
  input  fcls_e        yc,
  input  logic         psgn,
  output logic         hit,
  output logic [W-1:0] res,
  output logic         inv
);
  localparam logic [W-1:0] DNAN  = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
  localparam logic [W-2:0] INF_M = {{EXP_W{1'b1}}, {FRAC_W{1'b0}}};

  logic x_inf, y_inf, x_zero, y_zero, z_q, z_spec;

  assign x_inf  = (xc == CL_INF);
  assign y_inf  = (yc == CL_INF);
  assign x_zero = (xc == CL_ZERO);
  assign y_zero = (yc == CL_ZERO);
  assign z_q    = (zc == CL_QNAN);
  assign z_spec = z_q || (zc == CL_INF);

  always_comb begin
    hit = 1'b1;
    inv = 1'b0;
    res = '0;
    if ((x_inf && y_zero) || (x_zero && y_inf)) begin
      if (z_q) begin
        res = z;
      end else begin
        inv = 1'b1;
        res = DNAN;
      end
    end else if (x_inf || y_inf) begin
      res = z_q ? z : {psgn, INF_M};
    end else if (x_zero || y_zero) begin
      res = z;
    end else if (z_spec) begin
      res = z;
    end else begin
      hit = 1'b0;
    end
  end
endmodule

// File: rtl/fma_sc_resolve.sv
module fma_sc_resolve
  import fma_sc_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic         neg_prod,
  input  logic [W-1:0] op_z,
  input  logic [W-1:0] op_x,
  input  logic [W-1:0] op_y,
  output logic         byp_vld,
  output logic [W-1:0] byp_res,
  output logic         inv_op,
  output logic         prod_sgn,
  output logic [2:0]   z_cls,
  output logic [2:0]   x_cls,
  output logic [2:0]   y_cls
);
  localparam int NOPS = 3;

  logic [W-1:0] ops [NOPS];
  fcls_e        cls [NOPS];

  assign ops[0] = op_z;
  assign ops[1] = op_x;
  assign ops[2] = op_y;

  for (genvar i = 0; i < NOPS; i++) begin : g_cls
    fma_sc_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .op  (ops[i]),
      .cls (cls[i])
    );
  end

  logic         nan_hit, nan_inv, iz_hit, iz_inv;
  logic [W-1:0] nan_res, iz_res;

  assign prod_sgn = op_x[W-1] ^ op_y[W-1] ^ neg_prod;

  fma_sc_nan_pick #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_nan (
    .z   (op_z),
    .x   (op_x),
    .y   (op_y),
    .zc  (cls[0]),
    .xc  (cls[1]),
    .yc  (cls[2]),
    .hit (nan_hit),
    .res (nan_res),
    .inv (nan_inv)
  );

  fma_sc_infzero #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_iz (
    .z    (op_z),
    .zc   (cls[0]),
    .xc   (cls[1]),
    .yc   (cls[2]),
    .psgn (prod_sgn),
    .hit  (iz_hit),
    .res  (iz_res),
    .inv  (iz_inv)
  );

  always_comb begin
    if (nan_hit) begin
      byp_vld = 1'b1;
      byp_res = nan_res;
      inv_op  = nan_inv;
    end else begin
      byp_vld = iz_hit;
      byp_res = iz_res;
      inv_op  = iz_inv;
    end
  end

  assign z_cls = cls[0];
  assign x_cls = cls[1];
  assign y_cls = cls[2];
endmodule

// File: rtl/fma_sc_chk.sv
module fma_sc_chk #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input logic         neg_prod,
  input logic [W-1:0] op_z,
  input logic [W-1:0] op_x,
  input logic [W-1:0] op_y,
  input logic         byp_vld,
  input logic [W-1:0] byp_res,
  input logic         inv_op,
  input logic         prod_sgn,
  input logic [2:0]   z_cls
);
  localparam logic [W-1:0] QB   = {{(W-FRAC_W){1'b0}}, 1'b1, {(FRAC_W-1){1'b0}}};
  localparam logic [W-1:0] DNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  function automatic logic is_nan(input logic [W-1:0] v);
    return (&v[W-2 -: EXP_W]) && (v[FRAC_W-1:0] != '0);
  endfunction
  function automatic logic is_inf(input logic [W-1:0] v);
    return (&v[W-2 -: EXP_W]) && (v[FRAC_W-1:0] == '0);
  endfunction
  function automatic logic is_zero(input logic [W-1:0] v);
    return v[W-2:0] == '0;
  endfunction

  always_comb begin
    // R1
    cls_inf_chk: assert ((z_cls == 3'd5) == is_inf(op_z))
      else $error("addend infinity class mismatch");
    // R2
    zsnan_chk: assert (!(is_nan(op_z) && !op_z[FRAC_W-1]) ||
                       (byp_vld && inv_op && byp_res == (op_z | QB)))
      else $error("signalling addend not given priority");
    // R5
    dnan_chk: assert (!(((is_inf(op_x) && is_zero(op_y)) || (is_zero(op_x) && is_inf(op_y)))
                        && !is_nan(op_z)) || (byp_vld && inv_op && byp_res == DNAN))
      else $error("infinity times zero did not give default NaN");
    // R8
    pass_chk: assert (byp_vld || (byp_res == '0 && !inv_op))
      else $error("datapath case carries result or flag");
    // R9
    psign_chk: assert (prod_sgn == (op_x[W-1] ^ op_y[W-1] ^ neg_prod))
      else $error("product sign wrong");
  end
endmodule

bind fma_sc_resolve fma_sc_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .neg_prod (neg_prod),
  .op_z     (op_z),
  .op_x     (op_x),
  .op_y     (op_y),
  .byp_vld  (byp_vld),
  .byp_res  (byp_res),
  .inv_op   (inv_op),
  .prod_sgn (prod_sgn),
  .z_cls    (z_cls)
);

// File: tb/sim_fma_sc_resolve.sv
`timescale 1ns/1ps
module sim_fma_sc_resolve;
  logic        clk;
  logic        neg_prod;
  logic [31:0] op_z, op_x, op_y, byp_res;
  logic        byp_vld, inv_op, prod_sgn;
  logic [2:0]  z_cls, x_cls, y_cls;
  int          n_run, n_fail;
  bit          done;

  fma_sc_resolve u0 (
    .neg_prod (neg_prod), .op_z (op_z), .op_x (op_x), .op_y (op_y),
    .byp_vld (byp_vld), .byp_res (byp_res), .inv_op (inv_op),
    .prod_sgn (prod_sgn), .z_cls (z_cls), .x_cls (x_cls), .y_cls (y_cls)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  localparam int NV = 16;
  // {neg, z, x, y, exp_vld, exp_res, exp_inv}
  localparam logic [130:0] VEC [NV] = '{
    {1'b0, 32'h7F800001, 32'h7F800002, 32'h00000000, 1'b1, 32'h7FC00001, 1'b1}, // R2
    {1'b0, 32'h3F800000, 32'hFF800003, 32'h7F800004, 1'b1, 32'hFFC00003, 1'b1}, // R3 x wins
    {1'b0, 32'h3F800000, 32'h7FC00005, 32'h7F800004, 1'b1, 32'h7FC00004, 1'b1}, // R3 y only
    {1'b0, 32'h7FC00007, 32'h7FC00005, 32'h7FC00006, 1'b1, 32'h7FC00006, 1'b0}, // R4 y over x and z
    {1'b0, 32'h3F800000, 32'hFFC00009, 32'h40000000, 1'b1, 32'hFFC00009, 1'b0}, // R4 x only
    {1'b0, 32'h3F800000, 32'h7F800000, 32'h80000000, 1'b1, 32'h7FC00000, 1'b1}, // R5 default NaN
    {1'b0, 32'h7FC00007, 32'h00000000, 32'hFF800000, 1'b1, 32'h7FC00007, 1'b0}, // R5 quiet addend
    {1'b0, 32'h7F800000, 32'hFF800000, 32'h40000000, 1'b1, 32'hFF800000, 1'b0}, // R6 addend inf ignored
    {1'b1, 32'h3F800000, 32'h7F800000, 32'h00000001, 1'b1, 32'hFF800000, 1'b0}, // R6 negated
    {1'b0, 32'h7FC00007, 32'h7F800000, 32'h7F800000, 1'b1, 32'h7FC00007, 1'b0}, // R6 quiet addend
    {1'b1, 32'hFF800000, 32'h00000000, 32'h3F800000, 1'b1, 32'hFF800000, 1'b0}, // R7 inf addend
    {1'b0, 32'h40000000, 32'h00000001, 32'h80000000, 1'b1, 32'h40000000, 1'b0}, // R7 finite addend
    {1'b0, 32'hFF800000, 32'h3F800000, 32'h40000000, 1'b1, 32'hFF800000, 1'b0}, // R8 inf addend
    {1'b0, 32'h7FC00007, 32'h00000001, 32'h3F800000, 1'b1, 32'h7FC00007, 1'b0}, // R8 quiet addend
    {1'b0, 32'h3F800000, 32'h3F800000, 32'h40000000, 1'b0, 32'h00000000, 1'b0}, // R8 datapath
    {1'b0, 32'h00000001, 32'h00000001, 32'h00000001, 1'b0, 32'h00000000, 1'b0}  // R8 all denormal
  };
  localparam int RQ [NV] = '{2, 3, 3, 4, 4, 5, 5, 6, 6, 6, 7, 7, 8, 8, 8, 8};

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic n, input logic [31:0] z, input logic [31:0] x,
                       input logic [31:0] y);
    @(negedge clk);
    neg_prod = n; op_z = z; op_x = x; op_y = y;
    #2;
  endtask

  initial begin
    n_run = 0; n_fail = 0; done = 0;
    neg_prod = 0; op_z = '0; op_x = '0; op_y = '0;
    // quiescent state, zero product returns zero addend (R7)
    apply(0, 32'h0, 32'h0, 32'h0);
    chk("R7 idle", {byp_vld, inv_op, byp_res}, {1'b1, 1'b0, 32'h0});
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][130], VEC[i][129:98], VEC[i][97:66], VEC[i][65:34]);
      chk($sformatf("R%0d vec%0d", RQ[i], i), {byp_vld, inv_op, byp_res},
          {VEC[i][33], VEC[i][0], VEC[i][32:1]});
    end
    // R1 class codes
    apply(0, 32'h00000000, 32'h7F800001, 32'h7FC00000);
    chk("R1 snan/qnan/zero", {z_cls, x_cls, y_cls}, {3'd2, 3'd0, 3'd1});
    apply(0, 32'hFF800000, 32'h3F800000, 32'h00000001);
    chk("R1 inf/norm/dnorm", {z_cls, x_cls, y_cls}, {3'd5, 3'd3, 3'd4});
    // R9 product sign
    apply(1, 32'h3F800000, 32'hBF800000, 32'h3F800000);
    chk("R9 neg", prod_sgn, 1'b0);
    apply(0, 32'h3F800000, 32'hBF800000, 32'h3F800000);
    chk("R9 plain", prod_sgn, 1'b1);
    // R2 addend signalling beats quiet product NaN
    apply(0, 32'hFF812345, 32'h7FC00005, 32'h7FC00006);
    chk("R2 over qnan", {byp_vld, inv_op, byp_res}, {1'b1, 1'b1, 32'hFFC12345});
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int c = 0; c < 10000; c++) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=hung exp=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule